// File: doc/BRIEF.md
# Precise Exception and Return Unit

This block decides, once per completed instruction step, whether the step ends in an exception. It takes the raw cause vector of the step and filters it through the status register. If any cause survives, it runs the entry sequence. The status register is saved and cleared, and the surviving causes are recorded. A return pair and a data word are saved. The machine is then redirected to the fixed service entry.

The machine has a delayed program counter, so the unit keeps two addresses: the fetch PC and the delayed PC of the instruction being executed. The saved return pair depends on the cause class:
- **Abort-type causes** (reset, illegal instruction, misalignment, fetch or data page fault) save the pair unchanged, so the instruction runs again after return.
- **Continue-type causes** save the pair as it stands after the instruction has taken effect, including any taken branch.

A return-from-exception step restores the pair, the status and the privilege mode. When a step has neither an exception nor a return, it advances the pair in the normal way. The same steps can also carry a write into one of the special registers, as a move-to-special instruction does. The surrounding pipeline drives `step_i` high for each step that retires.

Top module: `prec_exc_unit`

## Requirements
- R1: After reset, every special register (SR, ESR, ECA, EPC, EDPC, EDATA, MODE, EMODE) reads zero, `pc_o` is 4 and `dpc_o` is 0.
- R2: A step with no exception and no return sets `dpc_o` to the old `pc_o`. It sets `pc_o` to `br_target_i` when `cf_taken_i` is high and to the old `pc_o` + 4 otherwise. While `step_i` is low, no register changes and `jisr_o` is low.
- R3: Cause bits 0 to 5 and bit 12 are never masked. Every other cause bit, including the external request bits 13 and up (request k at bit 12+k), counts only when the SR bit of the same index is 1. A step whose causes are all masked behaves as in R2.
- R4: On a step where any cause survives, `jisr_o` is high. At the next edge ESR takes the old SR, SR becomes 0, ECA takes the surviving cause vector, `pc_o` becomes 4 and `dpc_o` becomes 0.
- R5: When a surviving cause is among bits 0 to 4 (reset, illegal, misaligned, fetch page fault, data page fault), EPC takes the current `pc_o` and EDPC the current `dpc_o`.
- R6: Otherwise, EPC takes the advanced PC (branch target if taken, else PC+4) and EDPC takes the current `pc_o`.
- R7: On entry, EDATA is chosen by priority. A failed fetch (`fetch_fail_i`) gives the saved delayed PC. Failing that, a surviving trap (bit 5) gives `trap_imm_i`. Failing that, a surviving misalignment (bit 2) or data page fault (bit 4) gives `eff_addr_i`. Otherwise EDATA is 0.
- R8: On entry, EMODE takes MODE and MODE becomes 0 (system mode).
- R9: A return step (`rfe_i`) without a surviving cause loads `pc_o` from EPC, `dpc_o` from EDPC, SR from ESR and MODE from EMODE.
- R10: A surviving cause overrides a return and a special-register write in the same step. A return overrides a write. A write applies only on a step with neither. It loads `spr_wdata_i` into the register selected by `spr_sel_i`: 0 SR, 1 ESR, 2 EPC, 3 EDPC, 4 ECA, 5 EDATA, 6 MODE, 7 EMODE.
- R11: `user_mode_o` equals bit 0 of MODE; 1 means user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | An instruction step completes this cycle (clock enable) |
| cause_i | input | CAUSE_W | Raw cause vector of the step |
| fetch_fail_i | input | 1 | No instruction word was fetched this step |
| cf_taken_i | input | 1 | The step changes control flow |
| br_target_i | input | XLEN | Control-flow target |
| trap_imm_i | input | XLEN | Immediate of a trap instruction |
| eff_addr_i | input | XLEN | Effective address of a memory access |
| rfe_i | input | 1 | The step is a return from exception |
| spr_we_i | input | 1 | Write a special register |
| spr_sel_i | input | 3 | Special register selector |
| spr_wdata_i | input | XLEN | Write data |
| pc_o | output | XLEN | Fetch PC |
| dpc_o | output | XLEN | Delayed PC |
| jisr_o | output | 1 | Exception entry taken in this step |
| user_mode_o | output | 1 | Machine in user mode |
| sr_o | output | XLEN | Status / mask register |
| esr_o | output | XLEN | Saved status |
| eca_o | output | XLEN | Recorded causes |
| epc_o | output | XLEN | Saved PC |
| edpc_o | output | XLEN | Saved delayed PC |
| edata_o | output | XLEN | Saved exception data |
| mode_o | output | MODE_W | Current mode |
| emode_o | output | MODE_W | Saved mode |

## Verification
The bench uses several kinds of step to tell the behaviours apart:
- **Masked overflow and external requests.** A masked cause and an enabled one on the same bit separate the SR filter from the unmaskable set.
- **Branch taken or not under a continue-type cause.** This shows whether the saved pair was advanced, and through which path.
- **Abort-type faults.** Placing them after a branch makes the current pair unlike the advanced one, so a wrongly advanced save is visible.
- **Mixed cause combinations.** Trap with misalignment, and failed fetch with a page fault, expose the EDATA priority.
- **Simultaneous return, write and exception.** These expose the precedence order.
- **Random steps.** A long run of mixed steps is compared against a reference model.

// File: rtl/exc_pkg.sv
package exc_pkg;
  // cause bit positions decoded by the filter
  localparam int unsigned CB_RESET      = 0;
  localparam int unsigned CB_ILL        = 1;
  localparam int unsigned CB_MAL        = 2;
  localparam int unsigned CB_IPF        = 3;
  localparam int unsigned CB_DPF        = 4;
  localparam int unsigned CB_TRAP       = 5;
  localparam int unsigned CB_FPU_UNIMPL = 12;

  // restart vector after entry
  localparam logic [31:0] ENTRY_PC  = 32'd4;
  localparam logic [31:0] ENTRY_DPC = 32'd0;

  typedef enum logic [2:0] {
    SEL_SR    = 3'd0,
    SEL_ESR   = 3'd1,
    SEL_EPC   = 3'd2,
    SEL_EDPC  = 3'd3,
    SEL_ECA   = 3'd4,
    SEL_EDATA = 3'd5,
    SEL_MODE  = 3'd6,
    SEL_EMODE = 3'd7
  } spr_sel_e;

  typedef enum logic [1:0] {
    ED_ZERO = 2'd0,
    ED_DPC  = 2'd1,
    ED_TRAP = 2'd2,
    ED_ADDR = 2'd3
  } edata_src_e;
endpackage

// File: rtl/exc_cause_filter.sv
module exc_cause_filter
  import exc_pkg::*;
#(
  parameter int unsigned CAUSE_W = 32
) (
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [CAUSE_W-1:0] sr_i,
  input  logic               fetch_fail_i,
  output logic [CAUSE_W-1:0] pending_o,
  output logic               take_o,
  output logic               abort_o,
  output edata_src_e         edata_sel_o
);
  // per-bit mask stage: fixed set bypasses SR
  for (genvar b = 0; b < CAUSE_W; b++) begin : g_bit
    localparam bit UNMASKABLE = (b <= CB_TRAP) || (b == CB_FPU_UNIMPL);
    if (UNMASKABLE) begin : g_fixed
      assign pending_o[b] = cause_i[b];
    end else begin : g_masked
      assign pending_o[b] = cause_i[b] & sr_i[b];
    end
  end

  assign take_o  = |pending_o;
  assign abort_o = |pending_o[CB_DPF:CB_RESET];

  always_comb begin
    if (fetch_fail_i) begin
      edata_sel_o = ED_DPC;
    end else if (pending_o[CB_TRAP]) begin
      edata_sel_o = ED_TRAP;
    end else if (pending_o[CB_MAL] || pending_o[CB_DPF]) begin
      edata_sel_o = ED_ADDR;
    end else begin
      edata_sel_o = ED_ZERO;
    end
  end
endmodule

// File: rtl/exc_pc_seq.sv
module exc_pc_seq
  import exc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_i,
  input  logic            take_i,
  input  logic            abort_i,
  input  logic            rfe_i,
  input  logic            cf_taken_i,
  input  logic [XLEN-1:0] target_i,
  input  logic [XLEN-1:0] epc_i,
  input  logic [XLEN-1:0] edpc_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] dpc_o,
  output logic [XLEN-1:0] save_pc_o,
  output logic [XLEN-1:0] save_dpc_o
);
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);
  localparam logic [XLEN-1:0] RST_PC     = XLEN'(ENTRY_PC);
  localparam logic [XLEN-1:0] RST_DPC    = XLEN'(ENTRY_DPC);

  logic [XLEN-1:0] pc_q, dpc_q, pc_n, dpc_n;
  logic [XLEN-1:0] adv_pc, adv_dpc;

  // pair after the instruction takes effect
  always_comb begin
    adv_pc  = cf_taken_i ? target_i : (pc_q + INSN_BYTES);
    adv_dpc = pc_q;
  end

  // abort-type causes keep the pair as it is, for a repeat
  always_comb begin
    save_pc_o  = abort_i ? pc_q  : adv_pc;
    save_dpc_o = abort_i ? dpc_q : adv_dpc;
  end

  always_comb begin
    pc_n  = pc_q;
    dpc_n = dpc_q;
    if (step_i) begin
      if (take_i) begin
        pc_n  = RST_PC;
        dpc_n = RST_DPC;
      end else if (rfe_i) begin
        pc_n  = epc_i;
        dpc_n = edpc_i;
      end else begin
        pc_n  = adv_pc;
        dpc_n = adv_dpc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RST_PC;
      dpc_q <= RST_DPC;
    end else if (step_i) begin
      pc_q  <= pc_n;
      dpc_q <= dpc_n;
    end
  end

  assign pc_o  = pc_q;
  assign dpc_o = dpc_q;
endmodule

// File: rtl/exc_spr_file.sv
module exc_spr_file
  import exc_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 32,
  parameter int unsigned MODE_W  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_i,
  input  logic               take_i,
  input  logic               rfe_i,
  input  logic [CAUSE_W-1:0] pending_i,
  input  logic [XLEN-1:0]    save_pc_i,
  input  logic [XLEN-1:0]    save_dpc_i,
  input  edata_src_e         edata_sel_i,
  input  logic [XLEN-1:0]    trap_imm_i,
  input  logic [XLEN-1:0]    eff_addr_i,
  input  logic               wr_en_i,
  input  spr_sel_e           wr_sel_i,
  input  logic [XLEN-1:0]    wr_data_i,
  output logic [XLEN-1:0]    sr_o,
  output logic [XLEN-1:0]    esr_o,
  output logic [XLEN-1:0]    eca_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [XLEN-1:0]    edpc_o,
  output logic [XLEN-1:0]    edata_o,
  output logic [MODE_W-1:0]  mode_o,
  output logic [MODE_W-1:0]  emode_o
);
  logic [XLEN-1:0]   sr_q, esr_q, eca_q, epc_q, edpc_q, edata_q;
  logic [XLEN-1:0]   sr_n, esr_n, eca_n, epc_n, edpc_n, edata_n;
  logic [MODE_W-1:0] mode_q, emode_q, mode_n, emode_n;
  logic [XLEN-1:0]   edata_val;

  always_comb begin
    unique case (edata_sel_i)
      ED_DPC:  edata_val = save_dpc_i;
      ED_TRAP: edata_val = trap_imm_i;
      ED_ADDR: edata_val = eff_addr_i;
      default: edata_val = '0;
    endcase
  end

  always_comb begin
    sr_n    = sr_q;
    esr_n   = esr_q;
    eca_n   = eca_q;
    epc_n   = epc_q;
    edpc_n  = edpc_q;
    edata_n = edata_q;
    mode_n  = mode_q;
    emode_n = emode_q;
    if (step_i) begin
      if (take_i) begin
        esr_n   = sr_q;
        sr_n    = '0;
        eca_n   = XLEN'(pending_i);
        epc_n   = save_pc_i;
        edpc_n  = save_dpc_i;
        edata_n = edata_val;
        emode_n = mode_q;
        mode_n  = '0;
      end else if (rfe_i) begin
        sr_n   = esr_q;
        mode_n = emode_q;
      end else if (wr_en_i) begin
        unique case (wr_sel_i)
          SEL_SR:    sr_n    = wr_data_i;
          SEL_ESR:   esr_n   = wr_data_i;
          SEL_EPC:   epc_n   = wr_data_i;
          SEL_EDPC:  edpc_n  = wr_data_i;
          SEL_ECA:   eca_n   = wr_data_i;
          SEL_EDATA: edata_n = wr_data_i;
          SEL_MODE:  mode_n  = wr_data_i[MODE_W-1:0];
          SEL_EMODE: emode_n = wr_data_i[MODE_W-1:0];
          default:   sr_n    = sr_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      esr_q   <= '0;
      eca_q   <= '0;
      epc_q   <= '0;
      edpc_q  <= '0;
      edata_q <= '0;
      mode_q  <= '0;
      emode_q <= '0;
    end else if (step_i) begin
      sr_q    <= sr_n;
      esr_q   <= esr_n;
      eca_q   <= eca_n;
      epc_q   <= epc_n;
      edpc_q  <= edpc_n;
      edata_q <= edata_n;
      mode_q  <= mode_n;
      emode_q <= emode_n;
    end
  end

  assign sr_o    = sr_q;
  assign esr_o   = esr_q;
  assign eca_o   = eca_q;
  assign epc_o   = epc_q;
  assign edpc_o  = edpc_q;
  assign edata_o = edata_q;
  assign mode_o  = mode_q;
  assign emode_o = emode_q;
endmodule

// File: rtl/prec_exc_unit.sv
module prec_exc_unit
  import exc_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 32,
  parameter int unsigned MODE_W  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               fetch_fail_i,
  input  logic               cf_taken_i,
  input  logic [XLEN-1:0]    br_target_i,
  input  logic [XLEN-1:0]    trap_imm_i,
  input  logic [XLEN-1:0]    eff_addr_i,
  input  logic               rfe_i,
  input  logic               spr_we_i,
  input  logic [2:0]         spr_sel_i,
  input  logic [XLEN-1:0]    spr_wdata_i,
  output logic [XLEN-1:0]    pc_o,
  output logic [XLEN-1:0]    dpc_o,
  output logic               jisr_o,
  output logic               user_mode_o,
  output logic [XLEN-1:0]    sr_o,
  output logic [XLEN-1:0]    esr_o,
  output logic [XLEN-1:0]    eca_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [XLEN-1:0]    edpc_o,
  output logic [XLEN-1:0]    edata_o,
  output logic [MODE_W-1:0]  mode_o,
  output logic [MODE_W-1:0]  emode_o
);
  logic [CAUSE_W-1:0] pending;
  logic               take, abort;
  edata_src_e         edata_sel;
  logic [XLEN-1:0]    save_pc, save_dpc;

  exc_cause_filter #(.CAUSE_W(CAUSE_W)) u_filter (
    .cause_i      (cause_i),
    .sr_i         (sr_o[CAUSE_W-1:0]),
    .fetch_fail_i (fetch_fail_i),
    .pending_o    (pending),
    .take_o       (take),
    .abort_o      (abort),
    .edata_sel_o  (edata_sel)
  );

  exc_pc_seq #(.XLEN(XLEN)) u_pcseq (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step_i),
    .take_i     (take),
    .abort_i    (abort),
    .rfe_i      (rfe_i),
    .cf_taken_i (cf_taken_i),
    .target_i   (br_target_i),
    .epc_i      (epc_o),
    .edpc_i     (edpc_o),
    .pc_o       (pc_o),
    .dpc_o      (dpc_o),
    .save_pc_o  (save_pc),
    .save_dpc_o (save_dpc)
  );

  exc_spr_file #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .MODE_W(MODE_W)) u_spr (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (step_i),
    .take_i      (take),
    .rfe_i       (rfe_i),
    .pending_i   (pending),
    .save_pc_i   (save_pc),
    .save_dpc_i  (save_dpc),
    .edata_sel_i (edata_sel),
    .trap_imm_i  (trap_imm_i),
    .eff_addr_i  (eff_addr_i),
    .wr_en_i     (spr_we_i),
    .wr_sel_i    (spr_sel_e'(spr_sel_i)),
    .wr_data_i   (spr_wdata_i),
    .sr_o        (sr_o),
    .esr_o       (esr_o),
    .eca_o       (eca_o),
    .epc_o       (epc_o),
    .edpc_o      (edpc_o),
    .edata_o     (edata_o),
    .mode_o      (mode_o),
    .emode_o     (emode_o)
  );

  assign jisr_o      = step_i & take;
  assign user_mode_o = mode_o[0];
endmodule

// File: rtl/exc_checker.sv
module exc_checker #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 32,
  parameter int unsigned MODE_W  = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               step_i,
  input logic [CAUSE_W-1:0] cause_i,
  input logic               cf_taken_i,
  input logic               rfe_i,
  input logic               jisr_o,
  input logic [XLEN-1:0]    pc_o,
  input logic [XLEN-1:0]    dpc_o,
  input logic [XLEN-1:0]    sr_o,
  input logic [XLEN-1:0]    esr_o,
  input logic [XLEN-1:0]    epc_o,
  input logic [XLEN-1:0]    edpc_o,
  input logic [MODE_W-1:0]  mode_o,
  input logic [MODE_W-1:0]  emode_o
);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(pc_o) && $stable(dpc_o) && $stable(sr_o) && $stable(epc_o));

  assert_seq_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !jisr_o && !rfe_i && !cf_taken_i |=>
      pc_o == $past(pc_o) + XLEN'(4) && dpc_o == $past(pc_o));

  assert_fixed_causes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && (|cause_i[5:0]) |-> jisr_o);

  assert_entry_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
    jisr_o |=> pc_o == XLEN'(4) && dpc_o == '0 && sr_o == '0);

  assert_esr_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    jisr_o |=> esr_o == $past(sr_o));

  assert_abort_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    jisr_o && (|cause_i[4:0]) |=> epc_o == $past(pc_o) && edpc_o == $past(dpc_o));

  assert_mode_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    jisr_o |=> mode_o == '0 && emode_o == $past(mode_o));

  assert_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !jisr_o && rfe_i |=>
      pc_o == $past(epc_o) && dpc_o == $past(edpc_o) &&
      sr_o == $past(esr_o) && mode_o == $past(emode_o));
endmodule

bind prec_exc_unit exc_checker #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .MODE_W(MODE_W)) u_exc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_i     (step_i),
  .cause_i    (cause_i),
  .cf_taken_i (cf_taken_i),
  .rfe_i      (rfe_i),
  .jisr_o     (jisr_o),
  .pc_o       (pc_o),
  .dpc_o      (dpc_o),
  .sr_o       (sr_o),
  .esr_o      (esr_o),
  .epc_o      (epc_o),
  .edpc_o     (edpc_o),
  .mode_o     (mode_o),
  .emode_o    (emode_o)
);

// File: tb/test_prec_exc_unit.sv
`timescale 1ns/1ps
module test_prec_exc_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_i, fetch_fail_i, cf_taken_i, rfe_i, spr_we_i;
  logic [31:0] cause_i, br_target_i, trap_imm_i, eff_addr_i, spr_wdata_i;
  logic [2:0]  spr_sel_i;
  logic [31:0] pc_o, dpc_o, sr_o, esr_o, eca_o, epc_o, edpc_o, edata_o;
  logic        jisr_o, user_mode_o;
  logic [0:0]  mode_o, emode_o;

  always #2 clk = ~clk;

  prec_exc_unit i_prec_exc_unit (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .cause_i(cause_i),
    .fetch_fail_i(fetch_fail_i), .cf_taken_i(cf_taken_i), .br_target_i(br_target_i),
    .trap_imm_i(trap_imm_i), .eff_addr_i(eff_addr_i), .rfe_i(rfe_i),
    .spr_we_i(spr_we_i), .spr_sel_i(spr_sel_i), .spr_wdata_i(spr_wdata_i),
    .pc_o(pc_o), .dpc_o(dpc_o), .jisr_o(jisr_o), .user_mode_o(user_mode_o),
    .sr_o(sr_o), .esr_o(esr_o), .eca_o(eca_o), .epc_o(epc_o), .edpc_o(edpc_o),
    .edata_o(edata_o), .mode_o(mode_o), .emode_o(emode_o)
  );

  typedef struct {
    bit st; logic [31:0] cause; bit ff; bit cf; logic [31:0] tgt;
    logic [31:0] timm; logic [31:0] ea; bit rfe; bit we; logic [2:0] sel; logic [31:0] wd;
  } stim_t;

  typedef struct {
    string tag;
    logic [31:0] pc, dpc, sr, esr, eca, epc, edpc, edata;
    bit mode, emode;
  } exp_t;

  int checks = 0, fails = 0, issued = 0, popped = 0;
  exp_t q[$];

  // reference state
  logic [31:0] m_pc, m_dpc, m_sr, m_esr, m_eca, m_epc, m_edpc, m_edata;
  bit m_mode, m_emode;

  function automatic void chk(string tag, string fld, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
    end
  endfunction

  function automatic stim_t idle_step();
    stim_t s;
    s.st = 1'b1; s.cause = '0; s.ff = 1'b0; s.cf = 1'b0; s.tgt = '0;
    s.timm = '0; s.ea = '0; s.rfe = 1'b0; s.we = 1'b0; s.sel = '0; s.wd = '0;
    return s;
  endfunction

  function automatic bit model(stim_t s);
    logic [31:0] pend, adv_pc, sp, sd, ed;
    bit take, abort;
    if (!s.st) return 1'b0;
    pend   = s.cause & (m_sr | 32'h0000_103F);
    take   = |pend;
    abort  = |pend[4:0];
    adv_pc = s.cf ? s.tgt : m_pc + 32'd4;
    if (take) begin
      sp = abort ? m_pc : adv_pc;
      sd = abort ? m_dpc : m_pc;
      if (s.ff) ed = sd;
      else if (pend[5]) ed = s.timm;
      else if (pend[2] || pend[4]) ed = s.ea;
      else ed = '0;
      m_esr = m_sr; m_sr = '0; m_eca = pend; m_epc = sp; m_edpc = sd; m_edata = ed;
      m_emode = m_mode; m_mode = 1'b0; m_pc = 32'd4; m_dpc = '0;
    end else if (s.rfe) begin
      m_pc = m_epc; m_dpc = m_edpc; m_sr = m_esr; m_mode = m_emode;
    end else begin
      m_dpc = m_pc; m_pc = adv_pc;
      if (s.we) begin
        case (s.sel)
          3'd0: m_sr = s.wd;
          3'd1: m_esr = s.wd;
          3'd2: m_epc = s.wd;
          3'd3: m_edpc = s.wd;
          3'd4: m_eca = s.wd;
          3'd5: m_edata = s.wd;
          3'd6: m_mode = s.wd[0];
          default: m_emode = s.wd[0];
        endcase
      end
    end
    return take;
  endfunction

  task automatic drive(stim_t s, string tag);
    exp_t e;
    bit j;
    @(negedge clk);
    step_i = s.st; cause_i = s.cause; fetch_fail_i = s.ff; cf_taken_i = s.cf;
    br_target_i = s.tgt; trap_imm_i = s.timm; eff_addr_i = s.ea; rfe_i = s.rfe;
    spr_we_i = s.we; spr_sel_i = s.sel; spr_wdata_i = s.wd;
    j = model(s);
    #1;
    chk(tag, "jisr", {31'd0, jisr_o}, {31'd0, j});
    e.tag = tag; e.pc = m_pc; e.dpc = m_dpc; e.sr = m_sr; e.esr = m_esr; e.eca = m_eca;
    e.epc = m_epc; e.edpc = m_edpc; e.edata = m_edata; e.mode = m_mode; e.emode = m_emode;
    q.push_back(e);
    @(posedge clk);
    #1;
    issued++;
  endtask

  // monitor: compares each completed step away from the active edge
  always @(negedge clk) begin
    while (popped < issued && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "pc", pc_o, e.pc);
      chk(e.tag, "dpc", dpc_o, e.dpc);
      chk(e.tag, "sr", sr_o, e.sr);
      chk(e.tag, "esr", esr_o, e.esr);
      chk(e.tag, "eca", eca_o, e.eca);
      chk(e.tag, "epc", epc_o, e.epc);
      chk(e.tag, "edpc", edpc_o, e.edpc);
      chk(e.tag, "edata", edata_o, e.edata);
      chk(e.tag, "mode", {31'd0, mode_o}, {31'd0, e.mode});
      chk(e.tag, "emode", {31'd0, emode_o}, {31'd0, e.emode});
      chk({e.tag, "/R11"}, "user_mode", {31'd0, user_mode_o}, {31'd0, e.mode});
      popped++;
    end
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    stim_t s;
    rst_n = 1'b0; step_i = 0; cause_i = '0; fetch_fail_i = 0; cf_taken_i = 0;
    br_target_i = '0; trap_imm_i = '0; eff_addr_i = '0; rfe_i = 0; spr_we_i = 0;
    spr_sel_i = '0; spr_wdata_i = '0;
    m_pc = 32'd4; m_dpc = '0; m_sr = '0; m_esr = '0; m_eca = '0; m_epc = '0;
    m_edpc = '0; m_edata = '0; m_mode = 0; m_emode = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "pc", pc_o, 32'd4);
    chk("R1", "dpc", dpc_o, 32'd0);
    chk("R1", "sr", sr_o, 32'd0);
    chk("R1", "esr|eca|epc", esr_o | eca_o | epc_o, 32'd0);
    chk("R1", "edpc|edata", edpc_o | edata_o, 32'd0);
    chk("R1", "mode|emode", {30'd0, mode_o, emode_o}, 32'd0);

    // R2 sequential advance, then taken branch
    s = idle_step(); drive(s, "R2");
    s = idle_step(); s.cf = 1; s.tgt = 32'h100; drive(s, "R2");
    // R2 no step: causes and writes ignored
    s = idle_step(); s.st = 0; s.cause = 32'h2; s.we = 1; s.sel = 3'd0; s.wd = 32'hFFFF_FFFF;
    drive(s, "R2");
    // R3 masked overflow (SR = 0) behaves as a normal step
    s = idle_step(); s.cause = 32'h40; drive(s, "R3");
    // R10 write SR, then MODE (R11)
    s = idle_step(); s.we = 1; s.sel = 3'd0; s.wd = 32'h0000_00C0; drive(s, "R10");
    s = idle_step(); s.we = 1; s.sel = 3'd6; s.wd = 32'h1; drive(s, "R11");
    // R6 overflow enabled with a taken branch: continue-type save
    s = idle_step(); s.cause = 32'h40; s.cf = 1; s.tgt = 32'h200; drive(s, "R6");
    // R9 return restores pair, SR and MODE
    s = idle_step(); s.rfe = 1; drive(s, "R9");
    // R5 misalignment after a branch: abort-type save, EDATA = address (R7)
    s = idle_step(); s.cf = 1; s.tgt = 32'h300; drive(s, "R5");
    s = idle_step(); s.cause = 32'h4; s.ea = 32'hDEAD_0001; drive(s, "R5");
    // R7 trap wins over misalignment for EDATA
    s = idle_step(); s.cause = 32'h24; s.timm = 32'h77; s.ea = 32'h1234; drive(s, "R7");
    // R7 failed fetch with fetch page fault takes delayed PC
    s = idle_step(); drive(s, "R2");
    s = idle_step(); s.cause = 32'h8; s.ff = 1; s.timm = 32'h5; drive(s, "R7");
    // R3 external request bit 13: masked, then enabled
    s = idle_step(); s.cause = 32'h2000; drive(s, "R3");
    s = idle_step(); s.we = 1; s.sel = 3'd0; s.wd = 32'h2000; drive(s, "R10");
    s = idle_step(); s.cause = 32'h2000; drive(s, "R3");
    // R3 unimplemented floating-point cause with SR = 0
    s = idle_step(); s.cause = 32'h1000; drive(s, "R3");
    // R10 exception beats return and write in the same step
    s = idle_step(); s.cause = 32'h2; s.rfe = 1; s.we = 1; s.sel = 3'd5; s.wd = 32'hAAAA;
    drive(s, "R10");
    // R10 return beats write
    s = idle_step(); s.rfe = 1; s.we = 1; s.sel = 3'd5; s.wd = 32'h5555; drive(s, "R10");
    // R8 entry from user mode saves mode
    s = idle_step(); s.we = 1; s.sel = 3'd6; s.wd = 32'h1; drive(s, "R8");
    s = idle_step(); s.cause = 32'h20; s.timm = 32'h9; drive(s, "R8");
    // R4 mixed random steps against the model
    for (int i = 0; i < 400; i++) begin
      s = idle_step();
      s.st = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 3) == 0) s.cause = 32'h1 << $urandom_range(0, 20);
      s.ff = ($urandom_range(0, 15) == 0);
      s.cf = $urandom_range(0, 1);
      s.tgt = $urandom & 32'hFFFF_FFFC;
      s.timm = $urandom; s.ea = $urandom;
      s.rfe = ($urandom_range(0, 7) == 0);
      s.we = ($urandom_range(0, 4) == 0);
      s.sel = 3'($urandom_range(0, 7));
      s.wd = $urandom;
      drive(s, "R4");
    end
    @(negedge clk);
    step_i = 0;
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule